// File: doc/BRIEF.md
# Bridge Parity Error Response Controller

This block sits on the primary side of a bridge that joins two buses. It watches every qualified data phase, checks even parity over the address/data lines, the byte enables and the parity line, and then applies a response policy. The policy depends on the kind of transaction in flight and on the parity-error-response enables of both sides. Writes that travel downstream with bad data are either dropped or forwarded with the error kept, depending on the primary enable. Reads fetched upstream and configuration writes are never blocked. They are only flagged.

The parity check runs over two register stages, because the parity line trails its data phase by one clock. Every action appears two clocks after the data phase. The actions are a forward/drop decision for the write queue, a one-clock active-low PERR pulse, a poison tag for returned read data, and two sticky status flags that are cleared by writing 1. For upstream writes the bridge is the initiator. It does not check parity itself. It watches the target's PERR and can reflect the error to the secondary initiator when that initiator completes.

Top module: `perr_resp_ctrl`

## Requirements
- R1: Parity is even over the data lines, the byte enables and the parity bit. The parity bit is sampled one clock after the data phase it covers. A matching word produces no action.
- R2: Checking applies only to downstream writes (class 1), upstream reads (class 4) and configuration writes (class 5), and only when both ready inputs are high. Downstream reads (class 3), configuration reads (class 6) and phases without both readies cause no action.
- R3: A downstream write with bad parity and the primary enable clear is forwarded with `fwd_keep_o`=1 and `fwd_poison_o`=1. It sets the parity-error flag and leaves primary PERR high.
- R4: A downstream write with bad parity and the primary enable set is dropped with `fwd_keep_o`=0. It sets the parity-error flag and pulses primary PERR.
- R5: Every qualified downstream write produces `fwd_valid_o` two clocks after its data phase, whatever its parity. `ds_stop_o` accompanies it when more than one data phase was requested. Good parity gives keep=1 and poison=0.
- R6: An upstream write whose target drives primary PERR low two clocks after the data phase sets the data-parity flag only when the primary enable is set. It never sets the parity-error flag.
- R7: When R6 happens with both enables set, secondary PERR goes low for one clock after the next clock on which `sec_cmpl_i` is high. Otherwise secondary PERR stays high.
- R8: An upstream read with bad parity pulses `rd_poison_o` and sets the parity-error flag. With the primary enable set it also sets the data-parity flag and pulses primary PERR.
- R9: A configuration write with bad parity sets the parity-error flag. It pulses primary PERR only when the primary enable is set.
- R10: Primary PERR is low for exactly one clock per erroneous phase, from the second to the third clock edge after that phase.
- R11: Status flags are sticky. Bit 0 of `clr_bits_i` selects the parity-error flag and bit 1 selects the data-parity flag. A strobe with a 1 clears the selected flag and a 0 leaves it alone. A set on the same clock as a clear wins.
- R12: After reset both flags are 0, both PERR outputs are high and no forward decision is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | DATA_W | Address/data lines |
| be_i | input | DATA_W/8 | Byte enable lines |
| par_i | input | 1 | Parity line, one clock behind its data |
| init_rdy_i | input | 1 | Initiator ready seen on the bus |
| tgt_rdy_i | input | 1 | Target ready seen on the bus |
| xact_cls_i | input | 3 | Transaction class: 0 none, 1 downstream write, 2 upstream write, 3 downstream read, 4 upstream read, 5 config write, 6 config read |
| multi_i | input | 1 | More than one data phase requested |
| pri_per_en_i | input | 1 | Primary parity-error-response enable |
| sec_per_en_i | input | 1 | Secondary parity-error-response enable |
| p_perr_n_i | input | 1 | Primary PERR as driven by the target |
| sec_cmpl_i | input | 1 | Target ready returned to the secondary initiator for the pending write |
| clr_we_i | input | 1 | Status clear strobe |
| clr_bits_i | input | 2 | Write-1-to-clear mask for the status flags |
| fwd_valid_o | output | 1 | Forward decision valid for the write queue |
| fwd_keep_o | output | 1 | Keep and forward the queued write |
| fwd_poison_o | output | 1 | Forward the write with its parity error kept |
| ds_stop_o | output | 1 | Stop returned with the write |
| rd_poison_o | output | 1 | Returned read data carries bad parity |
| p_perr_n_o | output | 1 | Primary PERR drive, active low |
| s_perr_n_o | output | 1 | Secondary PERR drive, active low |
| sts_perr_det_o | output | 1 | Sticky parity-error-detected flag |
| sts_dpar_det_o | output | 1 | Sticky data-parity-detected flag |

## Verification
The assertions assume that both enable inputs stay constant from a data phase until its actions appear. They also assume that a phase reported as qualified really had both readies high two clocks earlier, and that the secondary completion strobe reflects a real completion. The stimulus only changes enables after the pipeline has drained. It strobes completion only when no upstream write is still in flight. It spaces data phases two clocks apart, so each parity bit lines up with its own phase.

// File: rtl/perr_pkg.sv
package perr_pkg;

    parameter int unsigned DATA_W_DEF = 32;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned STS_W = 2;
    localparam int unsigned STS_PERR_DET = 0;
    localparam int unsigned STS_DPAR_DET = 1;

    typedef enum logic [2:0] {
        XC_NONE   = 3'd0,
        XC_DS_WR  = 3'd1,
        XC_US_WR  = 3'd2,
        XC_DS_RD  = 3'd3,
        XC_US_RD  = 3'd4,
        XC_CFG_WR = 3'd5,
        XC_CFG_RD = 3'd6
    } xact_e;

    // first stage: the data phase seen on the bus
    typedef struct packed {
        logic  valid;
        xact_e cls;
        logic  multi;
    } ph_t;

    // second stage: the phase plus its parity verdict
    typedef struct packed {
        logic  valid;
        xact_e cls;
        logic  multi;
        logic  bad;
    } chk_t;

    // bridge is write target or read initiator on these classes
    function automatic logic cls_checked(xact_e c);
        return (c == XC_DS_WR) || (c == XC_US_RD) || (c == XC_CFG_WR);
    endfunction

endpackage

// File: rtl/perr_chk.sv
module perr_chk
    import perr_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DATA_W-1:0]          ad_i,
    input  logic [DATA_W/LANE_W-1:0]   be_i,
    input  logic                       par_i,
    input  logic                       init_rdy_i,
    input  logic                       tgt_rdy_i,
    input  logic [2:0]                 xact_cls_i,
    input  logic                       multi_i,
    output chk_t                       res_o
);
    localparam int unsigned BE_W = DATA_W / LANE_W;

    ph_t               s1;
    logic [DATA_W-1:0] s1_ad;
    logic [BE_W-1:0]   s1_be;
    logic [BE_W-1:0]   lane_par;
    logic              odd;
    xact_e             cls_in;

    assign cls_in = xact_e'(xact_cls_i);

    // stage 1: capture the qualified data phase
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= init_rdy_i && tgt_rdy_i && (cls_in != XC_NONE);
            s1.cls   <= cls_in;
            s1.multi <= multi_i;
        end
        s1_ad <= ad_i;
        s1_be <= be_i;
    end

    // per-lane parity tree, one byte plus its enable each
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_par[g] = (^s1_ad[g*LANE_W +: LANE_W]) ^ s1_be[g];
    end

    assign odd = (^lane_par) ^ par_i;

    // stage 2: parity line has arrived, form the verdict
    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
        end else begin
            res_o.valid <= s1.valid;
            res_o.cls   <= s1.cls;
            res_o.multi <= s1.multi;
            res_o.bad   <= s1.valid && cls_checked(s1.cls) && odd;
        end
    end

    AST_PHASE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        res_o.valid |-> $past(init_rdy_i && tgt_rdy_i, 2)); // R2

endmodule

// File: rtl/perr_policy.sv
module perr_policy
    import perr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  chk_t ph_i,
    input  logic pri_en_i,
    input  logic sec_en_i,
    input  logic p_perr_n_i,
    input  logic sec_cmpl_i,
    output logic set_perr_det_o,
    output logic set_dpar_det_o,
    output logic fwd_valid_o,
    output logic fwd_keep_o,
    output logic fwd_poison_o,
    output logic ds_stop_o,
    output logic rd_poison_o,
    output logic p_perr_n_o,
    output logic s_perr_n_o
);
    logic is_dsw;
    logic is_usr;
    logic is_usw;
    logic bad;
    logic drive_perr;
    logic tgt_perr_seen;
    logic set_pend;
    logic pend;

    always_comb begin
        is_dsw        = ph_i.valid && (ph_i.cls == XC_DS_WR);
        is_usr        = ph_i.valid && (ph_i.cls == XC_US_RD);
        is_usw        = ph_i.valid && (ph_i.cls == XC_US_WR);
        bad           = ph_i.valid && ph_i.bad;
        drive_perr    = bad && pri_en_i;
        tgt_perr_seen = is_usw && !p_perr_n_i;
        set_pend      = tgt_perr_seen && pri_en_i && sec_en_i;
        set_perr_det_o = bad;
        set_dpar_det_o = (is_usr && bad && pri_en_i) || (tgt_perr_seen && pri_en_i);
    end

    // decisions and primary PERR, all two clocks after the data phase
    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid_o  <= 1'b0;
            fwd_keep_o   <= 1'b0;
            fwd_poison_o <= 1'b0;
            ds_stop_o    <= 1'b0;
            rd_poison_o  <= 1'b0;
            p_perr_n_o   <= 1'b1;
        end else begin
            fwd_valid_o  <= is_dsw;
            fwd_keep_o   <= is_dsw && !(bad && pri_en_i);
            fwd_poison_o <= is_dsw && bad && !pri_en_i;
            ds_stop_o    <= is_dsw && ph_i.multi;
            rd_poison_o  <= is_usr && bad;
            p_perr_n_o   <= !drive_perr;
        end
    end

    // secondary PERR waits for the secondary completion
    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            s_perr_n_o <= 1'b1;
        end else if (sec_cmpl_i && pend) begin
            pend       <= set_pend;
            s_perr_n_o <= 1'b0;
        end else begin
            pend       <= pend || set_pend;
            s_perr_n_o <= 1'b1;
        end
    end

    AST_PERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !p_perr_n_o |-> $past(pri_en_i)); // R10
    AST_POISON_IS_KEPT: assert property (@(posedge clk) disable iff (rst)
        fwd_poison_o |-> fwd_valid_o && fwd_keep_o && p_perr_n_o); // R3
    AST_DROP_SIGNALLED: assert property (@(posedge clk) disable iff (rst)
        fwd_valid_o && !fwd_keep_o |-> !p_perr_n_o); // R4
    AST_STOP_WITH_FWD: assert property (@(posedge clk) disable iff (rst)
        ds_stop_o |-> fwd_valid_o); // R5
    AST_SPERR_AT_CMPL: assert property (@(posedge clk) disable iff (rst)
        !s_perr_n_o |-> $past(sec_cmpl_i) && $past(sec_en_i)); // R7

endmodule

// File: rtl/perr_sticky.sv
module perr_sticky #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_bits_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end else if (clr_we_i && clr_bits_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end

        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            $past(q_o[i]) && !($past(clr_we_i) && $past(clr_bits_i[i])) |-> q_o[i]); // R11
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            $past(set_i[i]) |-> q_o[i]); // R11
    end

endmodule

// File: rtl/perr_resp_ctrl.sv
module perr_resp_ctrl
    import perr_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DATA_W-1:0]        ad_i,
    input  logic [DATA_W/8-1:0]      be_i,
    input  logic                     par_i,
    input  logic                     init_rdy_i,
    input  logic                     tgt_rdy_i,
    input  logic [2:0]               xact_cls_i,
    input  logic                     multi_i,
    input  logic                     pri_per_en_i,
    input  logic                     sec_per_en_i,
    input  logic                     p_perr_n_i,
    input  logic                     sec_cmpl_i,
    input  logic                     clr_we_i,
    input  logic [1:0]               clr_bits_i,
    output logic                     fwd_valid_o,
    output logic                     fwd_keep_o,
    output logic                     fwd_poison_o,
    output logic                     ds_stop_o,
    output logic                     rd_poison_o,
    output logic                     p_perr_n_o,
    output logic                     s_perr_n_o,
    output logic                     sts_perr_det_o,
    output logic                     sts_dpar_det_o
);
    chk_t             ph;
    logic             set_perr_det;
    logic             set_dpar_det;
    logic [STS_W-1:0] sts_set;
    logic [STS_W-1:0] sts_q;

    perr_chk #(.DATA_W(DATA_W)) u_chk (
        .clk        (clk),
        .rst        (rst),
        .ad_i       (ad_i),
        .be_i       (be_i),
        .par_i      (par_i),
        .init_rdy_i (init_rdy_i),
        .tgt_rdy_i  (tgt_rdy_i),
        .xact_cls_i (xact_cls_i),
        .multi_i    (multi_i),
        .res_o      (ph)
    );

    perr_policy u_policy (
        .clk            (clk),
        .rst            (rst),
        .ph_i           (ph),
        .pri_en_i       (pri_per_en_i),
        .sec_en_i       (sec_per_en_i),
        .p_perr_n_i     (p_perr_n_i),
        .sec_cmpl_i     (sec_cmpl_i),
        .set_perr_det_o (set_perr_det),
        .set_dpar_det_o (set_dpar_det),
        .fwd_valid_o    (fwd_valid_o),
        .fwd_keep_o     (fwd_keep_o),
        .fwd_poison_o   (fwd_poison_o),
        .ds_stop_o      (ds_stop_o),
        .rd_poison_o    (rd_poison_o),
        .p_perr_n_o     (p_perr_n_o),
        .s_perr_n_o     (s_perr_n_o)
    );

    always_comb begin
        sts_set               = '0;
        sts_set[STS_PERR_DET] = set_perr_det;
        sts_set[STS_DPAR_DET] = set_dpar_det;
    end

    perr_sticky #(.N(STS_W)) u_sticky (
        .clk        (clk),
        .rst        (rst),
        .set_i      (sts_set),
        .clr_we_i   (clr_we_i),
        .clr_bits_i (clr_bits_i),
        .q_o        (sts_q)
    );

    assign sts_perr_det_o = sts_q[STS_PERR_DET];
    assign sts_dpar_det_o = sts_q[STS_DPAR_DET];

    AST_RDPOISON_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        rd_poison_o |-> sts_perr_det_o); // R8
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        fwd_valid_o && !fwd_keep_o |-> sts_perr_det_o); // R4

endmodule

// File: tb/test_perr_resp_ctrl.sv
module test_perr_resp_ctrl;
    import perr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  be = '0;
    logic        par = 1'b0;
    logic        irdy = 1'b0;
    logic        trdy = 1'b0;
    logic [2:0]  cls = 3'd0;
    logic        multi = 1'b0;
    logic        pri = 1'b0;
    logic        sec = 1'b0;
    logic        perr_in_n = 1'b1;
    logic        cmpl = 1'b0;
    logic        clr_we = 1'b0;
    logic [1:0]  clr_bits = '0;
    logic        fwd_valid, fwd_keep, fwd_poison, ds_stop, rd_poison;
    logic        p_perr_n, s_perr_n, sts_pe, sts_dp;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit ped_m = 0;
    bit dpd_m = 0;
    bit pend_m = 0;

    typedef struct {
        int         at;
        logic [5:0] v;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk; // 125 MHz

    perr_resp_ctrl i_perr_resp_ctrl (
        .clk(clk), .rst(rst), .ad_i(ad), .be_i(be), .par_i(par),
        .init_rdy_i(irdy), .tgt_rdy_i(trdy), .xact_cls_i(cls), .multi_i(multi),
        .pri_per_en_i(pri), .sec_per_en_i(sec), .p_perr_n_i(perr_in_n),
        .sec_cmpl_i(cmpl), .clr_we_i(clr_we), .clr_bits_i(clr_bits),
        .fwd_valid_o(fwd_valid), .fwd_keep_o(fwd_keep), .fwd_poison_o(fwd_poison),
        .ds_stop_o(ds_stop), .rd_poison_o(rd_poison), .p_perr_n_o(p_perr_n),
        .s_perr_n_o(s_perr_n), .sts_perr_det_o(sts_pe), .sts_dpar_det_o(sts_dp)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected pulses, otherwise expects idle outputs
    always @(negedge clk) begin
        if (!rst) begin
            logic [5:0] act;
            act = {fwd_valid, fwd_keep, fwd_poison, ds_stop, rd_poison, ~p_perr_n};
            if (q.size() != 0 && q[0].at == cyc) begin
                check(q[0].tag, {26'd0, act}, {26'd0, q[0].v}, "fwd/keep/poison/stop/rdpoison/perr");
                void'(q.pop_front());
            end else begin
                check("R2 R10", {26'd0, act}, 32'd0, "idle outputs");
            end
        end
    end

    task automatic phase(input xact_e c, input logic [31:0] a, input logic [3:0] b,
                         input bit mult, input bit corrupt, input bit rdy_ok, input string tag);
        bit chkd;
        bit bad;
        exp_t e;
        chkd = (c == XC_DS_WR) || (c == XC_US_RD) || (c == XC_CFG_WR);
        bad  = corrupt && chkd && rdy_ok;
        @(negedge clk);
        cls = c; ad = a; be = b; multi = mult; irdy = 1'b1; trdy = rdy_ok;
        if (rdy_ok && (c == XC_DS_WR || bad)) begin
            e.at  = cyc + 3;
            e.tag = tag;
            if (c == XC_DS_WR)
                e.v = {1'b1, !(bad && pri), bad && !pri, mult, 1'b0, bad && pri};
            else
                e.v = {4'b0000, c == XC_US_RD, bad && pri};
            q.push_back(e);
        end
        ped_m = ped_m | bad;
        dpd_m = dpd_m | (bad && pri && c == XC_US_RD);
        @(negedge clk);
        par = (^{a, b}) ^ corrupt;
        cls = 3'd0; irdy = 1'b0; trdy = 1'b0; multi = 1'b0;
    endtask

    task automatic usw(input bit seen);
        @(negedge clk);
        cls = XC_US_WR; ad = 32'h5555_AAAA; be = 4'hF; irdy = 1'b1; trdy = 1'b1;
        @(negedge clk);
        cls = 3'd0; irdy = 1'b0; trdy = 1'b0; par = 1'b1;
        @(negedge clk);
        perr_in_n = !seen;
        @(negedge clk);
        perr_in_n = 1'b1;
        dpd_m  = dpd_m | (seen && pri);
        pend_m = pend_m | (seen && pri && sec);
    endtask

    task automatic sec_done(input string req);
        @(negedge clk);
        cmpl = 1'b1;
        @(negedge clk);
        cmpl = 1'b0;
        check(req, {31'd0, s_perr_n}, {31'd0, !pend_m}, "secondary PERR at completion");
        @(negedge clk);
        check(req, {31'd0, s_perr_n}, 32'd1, "secondary PERR released");
        pend_m = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic sts(input string req);
        check(req, {31'd0, sts_pe}, {31'd0, ped_m}, "parity-error flag");
        check(req, {31'd0, sts_dp}, {31'd0, dpd_m}, "data-parity flag");
    endtask

    task automatic clr(input logic [1:0] bits);
        @(negedge clk);
        clr_we = 1'b1; clr_bits = bits;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = '0;
        if (bits[0]) ped_m = 0;
        if (bits[1]) dpd_m = 0;
    endtask

    task automatic en(input bit p, input bit s);
        @(negedge clk);
        pri = p; sec = s;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL all: watchdog expired actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12", {31'd0, sts_pe}, 32'd0, "flag after reset");
        check("R12", {31'd0, sts_dp}, 32'd0, "flag after reset");
        check("R12", {31'd0, p_perr_n}, 32'd1, "primary PERR after reset");
        check("R12", {31'd0, s_perr_n}, 32'd1, "secondary PERR after reset");
        check("R12", {31'd0, fwd_valid}, 32'd0, "forward valid after reset");

        // downstream writes, enables clear
        en(0, 0);
        phase(XC_DS_WR, 32'h1234_5678, 4'hF, 0, 0, 1, "R5");
        phase(XC_DS_WR, 32'hA5A5_0F0F, 4'h3, 1, 1, 1, "R3");
        settle();
        sts("R3");

        // write-1-to-clear
        clr(2'b00);
        sts("R11");
        clr(2'b01);
        sts("R11");

        // downstream writes, primary enable set; back-to-back PERR spacing
        en(1, 0);
        phase(XC_DS_WR, 32'hFFFF_FFFF, 4'h0, 0, 1, 1, "R4");
        phase(XC_DS_WR, 32'h0000_0000, 4'hF, 1, 0, 1, "R10");
        phase(XC_DS_WR, 32'h8000_0001, 4'h8, 1, 1, 1, "R4");
        settle();
        sts("R4");
        clr(2'b11);

        // classes and phases that must be ignored
        phase(XC_DS_RD, 32'h0BAD_F00D, 4'hF, 0, 1, 1, "R2");
        phase(XC_CFG_RD, 32'h1111_2222, 4'h1, 0, 1, 1, "R2");
        phase(XC_DS_WR, 32'h3333_4444, 4'h2, 0, 1, 0, "R2");
        settle();
        sts("R2");

        // good parity on varied words
        phase(XC_CFG_WR, 32'hDEAD_BEEF, 4'hA, 0, 0, 1, "R1");
        phase(XC_US_RD, 32'h0000_0100, 4'h1, 0, 0, 1, "R1");
        phase(XC_DS_WR, 32'h7FFF_FFFE, 4'h7, 0, 0, 1, "R1");
        settle();
        sts("R1");

        // configuration writes
        phase(XC_CFG_WR, 32'h0F0F_F0F0, 4'h5, 0, 1, 1, "R9");
        settle();
        sts("R9");
        clr(2'b11);
        en(0, 0);
        phase(XC_CFG_WR, 32'h0F0F_F0F1, 4'h5, 0, 1, 1, "R9");
        settle();
        sts("R9");
        clr(2'b11);

        // upstream reads
        phase(XC_US_RD, 32'hCAFE_0001, 4'hC, 0, 1, 1, "R8");
        settle();
        sts("R8");
        clr(2'b11);
        en(1, 0);
        phase(XC_US_RD, 32'hCAFE_0002, 4'hC, 0, 1, 1, "R8");
        settle();
        sts("R8");
        clr(2'b11);

        // set on the same clock as a clear
        phase(XC_DS_WR, 32'h0102_0304, 4'hF, 0, 1, 1, "R11");
        @(negedge clk);
        clr_we = 1'b1; clr_bits = 2'b11;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = '0;
        settle();
        sts("R11");
        clr(2'b11);

        // upstream writes observing the target's PERR
        en(0, 1);
        usw(1);
        settle();
        sts("R6");
        sec_done("R7");
        en(1, 0);
        usw(1);
        settle();
        sts("R6");
        sec_done("R7");
        clr(2'b11);
        en(1, 1);
        usw(0);
        settle();
        sts("R6");
        sec_done("R7");
        usw(1);
        settle();
        sts("R6");
        sec_done("R7");
        clr(2'b11);
        settle();
        sts("R11");

        check("R5", q.size(), 32'd0, "expected pulses left unseen");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule